// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. A write to its control register starts a sequence of four conversions. For each conversion it closes the sample switch for a fixed window, drives trial codes onto the capacitor-array switches from the most significant bit down, and reads a one-bit comparator to decide each bit. The four finished codes are placed in four result registers, and a completion flag is raised when the last of the four is stored.

The control word selects the channel or channel group. It also chooses between two sequencing modes. In the first, one channel is converted four times. In the second, a group of four channels is converted in order. It also chooses whether the sequence stops after four results or keeps cycling through them. A separate power bit gates the whole converter. After the power bit is set, a programmable settling count must elapse before any sampling begins.

Top module: `sar_seq`

## Requirements
- R1: After reset the power bit is off, the control bits and the completion flag read 0, every result register is 0, `sample_sw` is 0 and `dac_bits` is 0.
- R2: No sampling starts while power is off. After `pwr_wr` sets power at edge P0, `sample_sw` stays 0 through edge P0+`warm_limit`-1 and becomes 1 after edge P0+`warm_limit` if a sequence is pending. Writing power to 0 halts the sequence and idles `sample_sw` and `dac_bits` from the next cycle.
- R3: Each conversion takes 32 cycles. During the first 12 of them `sample_sw` is 1 and `dac_bits` is all zero.
- R4: Bits are decided from MSB to LSB. A trial bit is applied for one cycle. In the following cycle `cmp_in`=1 keeps it and `cmp_in`=0 clears it. With a comparator that returns 1 when the input is at or above the trial code, the result is exactly the input code, including 0x00 and 0xFF.
- R5: A result register changes only when the LSB of its conversion is decided, at the 28th edge of that conversion.
- R6: Control bits [2:0] select the channel. With bit 4 (multi) at 0, that channel is converted four times, into results 0, 1, 2 and 3 in turn, and `chan_sel` shows it.
- R7: With bit 4 at 1, bit 2 selects the group: channels 0–3 or channels 4–7. Result k holds channel {bit2, k}.
- R8: With bit 5 (scan) at 0, the completion flag rises at the 128th edge after the control write. The block then stops: `sample_sw` stays 0 and the results hold.
- R9: With bit 5 at 1, conversions continue round-robin and keep refreshing the results. The flag stays 1 once it has been set.
- R10: `ctl_rdata` returns the six written control bits in [5:0], 0 in bit 6 and the flag in bit 7. A control write clears the flag and restarts the sequence at result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_wr | input | 1 | Write strobe for the power bit |
| pwr_wdata | input | 1 | Power bit value |
| warm_limit | input | WARM_W | Settling cycles after power-on |
| ctl_wr | input | 1 | Control write strobe; starts a sequence |
| ctl_wdata | input | 6 | Control bits: [5] scan, [4] multi, [3] spare, [2:0] channel |
| ctl_rdata | output | 8 | Readback: flag, 0, control bits |
| cmp_in | input | 1 | Comparator decision |
| sample_sw | output | 1 | Sample switch enable |
| dac_bits | output | RES_W | Capacitor-array trial switches |
| chan_sel | output | 3 | Analog input multiplexer select |
| results | output | 4*RES_W | Result registers; result k at [k*RES_W +: RES_W] |

## Verification
The bench builds the block with its default 8-bit resolution, 32-cycle conversion and 12-cycle sample window, and it drives `warm_limit` to 20. The short settling count lets the power gating edge and a full sequence be observed cycle by cycle. The bench's comparator model returns the exact input code for each channel, so every result can be predicted. Extreme codes 0x00 and 0xFF, both channel groups and both scan modes can all be reached within a few thousand cycles.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W      = 8,
  parameter int CONV_CYC   = 32,
  parameter int SAMPLE_CYC = 12,
  parameter int WARM_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_wr,
  input  logic                 pwr_wdata,
  input  logic [WARM_W-1:0]    warm_limit,
  input  logic                 ctl_wr,
  input  logic [5:0]           ctl_wdata,
  output logic [7:0]           ctl_rdata,
  input  logic                 cmp_in,
  output logic                 sample_sw,
  output logic [RES_W-1:0]     dac_bits,
  output logic [2:0]           chan_sel,
  output logic [4*RES_W-1:0]   results
);
  localparam int CNT_W     = $clog2(CONV_CYC);
  localparam int TRIAL_LEN = 2 * RES_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYC - 1);

  logic              pwr;
  logic [WARM_W-1:0] warm_cnt;
  logic [5:0]        ctl;
  logic              done, run;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        slot;
  logic [RES_W-1:0]  sar, sar_nx, trial;
  logic [RES_W-1:0]  res [4];
  logic              ready, active, in_trial, last;
  int                off;

  assign ready     = pwr && (warm_cnt == warm_limit);
  assign active    = run && ready;
  assign sample_sw = active && (int'(cnt) < SAMPLE_CYC);
  assign dac_bits  = active ? sar : '0;
  assign chan_sel  = ctl[4] ? {ctl[2], slot} : ctl[2:0];
  assign ctl_rdata = {done, 1'b0, ctl};

  always_comb begin
    off      = int'(cnt) - SAMPLE_CYC;
    in_trial = active && (off >= 0) && (off < TRIAL_LEN);
    trial    = '0;
    if (in_trial) trial[RES_W - 1 - off / 2] = 1'b1;
    last     = in_trial && (off == TRIAL_LEN - 1);
    if (!in_trial)   sar_nx = sar;
    else if (!off[0]) sar_nx = sar | trial;
    else              sar_nx = cmp_in ? sar : (sar & ~trial);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr      <= 1'b0;
      warm_cnt <= '0;
    end else if (pwr_wr) begin
      pwr      <= pwr_wdata;
      warm_cnt <= '0;
    end else if (pwr && warm_cnt != warm_limit) begin
      warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      done <= 1'b0;
      run  <= 1'b0;
      cnt  <= '0;
      slot <= '0;
      sar  <= '0;
      for (int i = 0; i < 4; i++) res[i] <= '0;
    end else if (ctl_wr) begin
      ctl  <= ctl_wdata;
      done <= 1'b0;
      run  <= 1'b1;
      cnt  <= '0;
      slot <= '0;
      sar  <= '0;
    end else if (pwr_wr && !pwr_wdata) begin
      run  <= 1'b0;
      cnt  <= '0;
      slot <= '0;
      sar  <= '0;
    end else if (active) begin
      sar <= sar_nx;
      if (last) res[slot] <= sar_nx;
      if (cnt == CNT_LAST) begin
        cnt  <= '0;
        sar  <= '0;
        slot <= slot + 1'b1;
        if (slot == 2'd3) begin
          done <= 1'b1;
          if (!ctl[5]) run <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_res
    assign results[k*RES_W +: RES_W] = res[k];
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_wr,
  input logic               pwr_wdata,
  input logic               ctl_wr,
  input logic [7:0]         ctl_rdata,
  input logic               sample_sw,
  input logic [RES_W-1:0]   dac_bits,
  input logic [4*RES_W-1:0] results
);
  AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sample_sw |-> dac_bits == '0); // R3

  AST_PWR_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && !pwr_wdata && !ctl_wr) |=> (!sample_sw && dac_bits == '0)); // R2

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl_rdata[7]); // R10

  AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] == 1'b0); // R10

  AST_SCAN_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && ctl_rdata[5] && !ctl_wr) |=> ctl_rdata[7]); // R9

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && !ctl_rdata[5] && !ctl_wr) |=> (!sample_sw && $stable(results))); // R8
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  localparam int CLK_P = 10;
  localparam int RW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_wr = 1'b0, pwr_wdata = 1'b0;
  logic [15:0]   warm_limit = 16'd20;
  logic          ctl_wr = 1'b0;
  logic [5:0]    ctl_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic          cmp_in;
  logic          sample_sw;
  logic [RW-1:0] dac_bits;
  logic [2:0]    chan_sel;
  logic [4*RW-1:0] results;
  logic [7:0]    ana [8];
  int errs = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;
  assign cmp_in = ana[chan_sel] >= dac_bits;

  sar_seq u0 (.clk, .rst_n, .pwr_wr, .pwr_wdata, .warm_limit, .ctl_wr, .ctl_wdata,
              .ctl_rdata, .cmp_in, .sample_sw, .dac_bits, .chan_sel, .results);

  // {ctl[5:0], seed[7:0]}
  localparam logic [13:0] VEC [6] = '{
    {6'h00, 8'h11}, {6'h05, 8'h3C}, {6'h10, 8'h00},
    {6'h14, 8'hA7}, {6'h0B, 8'hF0}, {6'h13, 8'h5A}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_pwr(input logic v);
    @(negedge clk); pwr_wr = 1'b1; pwr_wdata = v;
    @(negedge clk); pwr_wr = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ana(input logic [7:0] seed);
    for (int i = 0; i < 8; i++) ana[i] = seed + 8'(i * 23);
  endtask

  task automatic chk_results(input string req, input logic [5:0] c);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      e = c[4] ? ana[{c[2], 2'(k)}] : ana[c[2:0]];
      chk(req, results[k*RW +: RW], e);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    set_ana(8'h11);
    edges(3);
    rst_n = 1'b1;
    edges(1);
    // R1 reset state
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 results", results, 0);
    chk("R1 sample", sample_sw, 0);
    chk("R1 dac", dac_bits, 0);

    // R2 no sampling without power
    wr_ctl(6'h00);
    edges(50);
    chk("R2 off sample", sample_sw, 0);
    chk("R2 off flag", ctl_rdata[7], 0);
    wr_pwr(1'b1);
    edges(19);
    chk("R2 warm not yet", sample_sw, 0);
    edges(1);
    chk("R2 warm done", sample_sw, 1);
    chk("R3 dac quiet", dac_bits, 0);
    edges(11);
    chk("R3 last sample cycle", sample_sw, 1);
    edges(1);
    chk("R3 sample window end", sample_sw, 0);
    edges(15);
    chk("R5 before last bit", results[RW-1:0], 0);
    edges(1);
    chk("R5 at last bit", results[RW-1:0], ana[0]);
    edges(99);
    chk("R8 flag early", ctl_rdata[7], 0);
    edges(1);
    chk("R8 flag at 128", ctl_rdata[7], 1);
    chk_results("R6 single ch0", 6'h00);

    // vector table: R4 R6 R7 R10
    for (int v = 0; v < 6; v++) begin
      logic [5:0] c;
      c = VEC[v][13:8];
      set_ana(VEC[v][7:0]);
      wr_ctl(c);
      edges(128);
      chk("R8 flag", ctl_rdata[7], 1);
      chk("R10 readback", ctl_rdata[6:0], {1'b0, c});
      chk_results(c[4] ? "R7 group" : "R6 single", c);
    end

    // R4 extremes
    for (int i = 0; i < 8; i++) ana[i] = (i < 4) ? 8'h00 : 8'hFF;
    wr_ctl(6'h10); edges(128);
    chk("R4 code 00", results, 32'h0);
    wr_ctl(6'h14); edges(128);
    chk("R4 code FF", results, 32'hFFFF_FFFF);

    // R8 halted: analog change must not reach results
    set_ana(8'h42);
    edges(64);
    chk("R8 halted results", results, 32'hFFFF_FFFF);
    chk("R8 halted sample", sample_sw, 0);

    // R9 scan
    set_ana(8'h21);
    wr_ctl(6'h30); edges(128);
    chk("R9 first flag", ctl_rdata[7], 1);
    chk_results("R9 first pass", 6'h30);
    set_ana(8'h9D);
    edges(128);
    chk("R9 flag sticky", ctl_rdata[7], 1);
    chk_results("R9 refreshed", 6'h30);

    // R10 write clears flag
    wr_ctl(6'h02);
    chk("R10 flag cleared", ctl_rdata[7], 0);
    chk("R10 bits", ctl_rdata[5:0], 6'h02);
    chk("R6 chan_sel", chan_sel, 3'd2);

    // R2 power off halts
    edges(5);
    wr_pwr(1'b0);
    chk("R2 off idle", sample_sw, 0);
    edges(200);
    chk("R2 off no flag", ctl_rdata[7], 0);
    chk("R2 off dac", dac_bits, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule